// File: doc/BRIEF.md
# Adaptive Voltage Level Calculator

This block turns one supply-voltage code for the fastest load level into a full set of four codes, one for each load level of a four-level dynamic frequency and voltage scheme. Each code is an index into a fixed 52-entry table of millivolt values. The table rises monotonically from 747 mV to 1342 mV. The lower load levels get targets that are fixed millivolt amounts below the base voltage, with a 1000 mV floor. A frequency class decides whether load level 1 also has a minimum voltage. Each target is turned back into a code by scanning the table upward, one entry per clock, until the first entry that meets or exceeds the target.

Software or a boot sequencer presents the base code and the frequency class and pulses `start_i`. The engine latches both values. It then runs three table scans in sequence: the level-1 target, the shared level-2/3 target, and the class minimum. It combines the three results and pulses `done_o`. The four result codes hold their values until the next successful run. A base code outside the table does not change them. It raises `err_o` instead.

The controller uses six states. IDLE goes to DECIDE when start is accepted. DECIDE goes to DONE when the base code is out of range, and otherwise goes to SRCH_L1. SRCH_L1 goes to SRCH_L23 when its scan hits. SRCH_L23 goes to SRCH_MIN when its scan hits. SRCH_MIN goes to DONE when its scan hits. DONE always returns to IDLE after one cycle.

Top module: `avl_calc`

## Requirements
- R1: While reset is held and after its release, all four level codes are 0, and `done_o` and `err_o` are low.
- R2: Code i stands for 747 + floor(35*i/3) millivolts for i = 0..51. With base code 51 (1342 mV) and class 0, level 1 is code 43 and levels 2/3 are code 39.
- R3: A scan returns the lowest code whose voltage is at or above the target. If no entry reaches the target, it returns code 51. With a level-1 minimum of 1400 mV, a base code of 51 and class 3, level 1 is 51.
- R4: A base code of 52 or more sets `err_o` in the cycle `done_o` pulses and leaves all four codes unchanged. The next in-range run clears `err_o` in its own done cycle.
- R5: If the base voltage is 1000 mV or less (base code 21 or below) and the class is 0 or 1, levels 1, 2 and 3 are code 22 (1003 mV) and level 0 is the base code.
- R6: In the same low-voltage case, class 2 sets levels 0 and 1 to code 31 (1108 mV), and class 3 sets them to code 35 (1155 mV). Levels 2 and 3 stay at code 22.
- R7: Otherwise level 0 is the base code. Level 1 matches max(base mV − 100, 1000). Levels 2 and 3 both match max(base mV − 150, 1000).
- R8: Outside the low-voltage case, classes 2 and 3 raise level 1 to at least min(M, base code). M is code 31 for class 2 and code 35 for class 3. Classes 0 and 1 apply no minimum. Class encoding: 0 = 600 MHz, 1 = 800 MHz, 2 = 1000 MHz, 3 = 1200 MHz.
- R9: `done_o` is high for exactly one cycle. The codes change only in that cycle. Let the accepting edge be edge 0. For an in-range base, done rises at edge r1+r2+rm+4. Here r1 and r2 are the level-1 and level-2/3 scan results, and rm is the result of scanning for 1155 mV (class 3) or 1108 mV (classes 0 to 2). For an out-of-range base, done rises at edge 1.
- R10: `start_i` is accepted only in IDLE. A start from the accepting edge through the done cycle is ignored and does not change the result or the timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, sampled in IDLE |
| base_code_i | input | 6 | Level-0 voltage code |
| freq_class_i | input | 2 | Maximum-frequency class (0..3) |
| lvl0_code_o | output | 6 | Level-0 result code |
| lvl1_code_o | output | 6 | Level-1 result code |
| lvl2_code_o | output | 6 | Level-2 result code |
| lvl3_code_o | output | 6 | Level-3 result code |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Last run had an out-of-range base code |

## Verification
The main instance uses the default parameters: a 52-entry table, a 1000 mV floor, and level-1 minimums of 1108 mV and 1155 mV. It covers the low-voltage and normal paths for every class, the code 21/22 boundary, the clamp of the minimum to the base code, and out-of-range codes. A second instance raises the class-3 minimum to 1400 mV. With that setting the scan runs off the top of the table, which brings the saturate-at-51 branch within reach. Under default settings no target ever gets there. The reference model predicts the completion edge from its own scan results, so a controller that adds or drops a cycle shows up as a mismatch.

// File: rtl/avl_pkg.sv
package avl_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_SRCH_L1,
        ST_SRCH_L23,
        ST_SRCH_MIN,
        ST_DONE
    } avl_state_e;

    typedef enum logic [1:0] {
        FCLS_600  = 2'd0,
        FCLS_800  = 2'd1,
        FCLS_1000 = 2'd2,
        FCLS_1200 = 2'd3
    } avl_cls_e;

    // Millivolt value of a table code: linear ramp with a rational step.
    function automatic int mv_of(input int code, input int base_mv,
                                 input int step_num, input int step_den);
        return base_mv + (code * step_num) / step_den;
    endfunction
endpackage

// File: rtl/avl_target.sv
module avl_target
    import avl_pkg::*;
#(
    parameter int CODE_W        = 6,
    parameter int TBL_N         = 52,
    parameter int MV_W          = 11,
    parameter int MV_BASE       = 747,
    parameter int STEP_NUM      = 35,
    parameter int STEP_DEN      = 3,
    parameter int FLOOR_MV      = 1000,
    parameter int DROP_L1_MV    = 100,
    parameter int DROP_L23_MV   = 150,
    parameter int MIN_L1_MID_MV = 1108,
    parameter int MIN_L1_TOP_MV = 1155
) (
    input  logic [CODE_W-1:0] base_i,
    input  avl_cls_e          cls_i,
    output logic              bad_o,
    output logic              low_o,
    output logic              apply_min_o,
    output logic [MV_W-1:0]   t_l1_o,
    output logic [MV_W-1:0]   t_l23_o,
    output logic [MV_W-1:0]   t_min_o
);
    timeunit 1ns;
    timeprecision 1ps;

    int base_mv;
    int drop1;
    int drop23;

    always_comb begin
        base_mv = mv_of(int'(base_i), MV_BASE, STEP_NUM, STEP_DEN);
        drop1   = base_mv - DROP_L1_MV;
        drop23  = base_mv - DROP_L23_MV;
        if (drop1 < FLOOR_MV) begin
            drop1 = FLOOR_MV;
        end
        if (drop23 < FLOOR_MV) begin
            drop23 = FLOOR_MV;
        end
    end

    assign bad_o       = int'(base_i) >= TBL_N;
    assign low_o       = base_mv <= FLOOR_MV;
    assign apply_min_o = (cls_i == FCLS_1000) || (cls_i == FCLS_1200);
    assign t_l1_o      = MV_W'(drop1);
    assign t_l23_o     = MV_W'(drop23);
    assign t_min_o     = (cls_i == FCLS_1200) ? MV_W'(MIN_L1_TOP_MV) : MV_W'(MIN_L1_MID_MV);
endmodule

// File: rtl/avl_search.sv
module avl_search
    import avl_pkg::*;
#(
    parameter int CODE_W   = 6,
    parameter int TBL_N    = 52,
    parameter int MV_W     = 11,
    parameter int MV_BASE  = 747,
    parameter int STEP_NUM = 35,
    parameter int STEP_DEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_i,
    input  logic [MV_W-1:0]   target_i,
    output logic              found_o,
    output logic [CODE_W-1:0] idx_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam logic [CODE_W-1:0] LAST_IDX = CODE_W'(TBL_N - 1);

    logic              busy_q;
    logic [CODE_W-1:0] idx_q;
    logic              reached;

    // Upward scan: one table entry per clock, stop at first entry >= target.
    always_comb begin
        reached = mv_of(int'(idx_q), MV_BASE, STEP_NUM, STEP_DEN) >= int'(target_i);
        found_o = busy_q && (reached || (idx_q == LAST_IDX));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            idx_q  <= '0;
        end else if (go_i) begin
            busy_q <= 1'b1;
            idx_q  <= '0;
        end else if (busy_q) begin
            if (found_o) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q + CODE_W'(1);
            end
        end
    end

    assign idx_o = idx_q;
endmodule

// File: rtl/avl_resolve.sv
module avl_resolve #(
    parameter int CODE_W = 6
) (
    input  logic [CODE_W-1:0] base_i,
    input  logic              low_i,
    input  logic              apply_min_i,
    input  logic [CODE_W-1:0] r_l1_i,
    input  logic [CODE_W-1:0] r_l23_i,
    input  logic [CODE_W-1:0] r_min_i,
    output logic [CODE_W-1:0] lvl0_o,
    output logic [CODE_W-1:0] lvl1_o,
    output logic [CODE_W-1:0] lvl2_o,
    output logic [CODE_W-1:0] lvl3_o
);
    timeunit 1ns;
    timeprecision 1ps;

    logic [CODE_W-1:0] min_clamped;

    // The class minimum never pushes level 1 above the base code.
    assign min_clamped = (r_min_i > base_i) ? base_i : r_min_i;

    always_comb begin
        if (low_i) begin
            lvl1_o = apply_min_i ? r_min_i : r_l1_i;
            lvl0_o = apply_min_i ? r_min_i : base_i;
            lvl2_o = r_l1_i;
            lvl3_o = r_l1_i;
        end else begin
            lvl0_o = base_i;
            lvl1_o = (apply_min_i && (r_l1_i < min_clamped)) ? min_clamped : r_l1_i;
            lvl2_o = r_l23_i;
            lvl3_o = r_l23_i;
        end
    end
endmodule

// File: rtl/avl_ctrl.sv
module avl_ctrl
    import avl_pkg::*;
#(
    parameter int CODE_W = 6,
    parameter int MV_W   = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CODE_W-1:0] base_i,
    input  logic [1:0]        cls_i,
    input  logic              bad_i,
    input  logic [MV_W-1:0]   t_l1_i,
    input  logic [MV_W-1:0]   t_l23_i,
    input  logic [MV_W-1:0]   t_min_i,
    input  logic              found_i,
    input  logic [CODE_W-1:0] idx_i,
    input  logic [CODE_W-1:0] res_l0_i,
    input  logic [CODE_W-1:0] res_l1_i,
    input  logic [CODE_W-1:0] res_l2_i,
    input  logic [CODE_W-1:0] res_l3_i,
    output logic              go_o,
    output logic [MV_W-1:0]   target_o,
    output logic [CODE_W-1:0] base_q_o,
    output avl_cls_e          cls_q_o,
    output logic [CODE_W-1:0] r_l1_o,
    output logic [CODE_W-1:0] r_l23_o,
    output logic [CODE_W-1:0] lvl0_o,
    output logic [CODE_W-1:0] lvl1_o,
    output logic [CODE_W-1:0] lvl2_o,
    output logic [CODE_W-1:0] lvl3_o,
    output logic              done_o,
    output logic              err_o
);
    timeunit 1ns;
    timeprecision 1ps;

    avl_state_e state_q;
    avl_state_e state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and state outputs.
    always_comb begin
        state_d  = state_q;
        go_o     = 1'b0;
        target_o = '0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    state_d = ST_DECIDE;
                end
            end
            ST_DECIDE: begin
                if (bad_i) begin
                    state_d = ST_DONE;
                end else begin
                    go_o    = 1'b1;
                    state_d = ST_SRCH_L1;
                end
            end
            ST_SRCH_L1: begin
                target_o = t_l1_i;
                if (found_i) begin
                    go_o    = 1'b1;
                    state_d = ST_SRCH_L23;
                end
            end
            ST_SRCH_L23: begin
                target_o = t_l23_i;
                if (found_i) begin
                    go_o    = 1'b1;
                    state_d = ST_SRCH_MIN;
                end
            end
            ST_SRCH_MIN: begin
                target_o = t_min_i;
                if (found_i) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                done_o  = 1'b1;
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Latched request, intermediate scan results and published codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q_o <= '0;
            cls_q_o  <= FCLS_600;
            r_l1_o   <= '0;
            r_l23_o  <= '0;
            lvl0_o   <= '0;
            lvl1_o   <= '0;
            lvl2_o   <= '0;
            lvl3_o   <= '0;
            err_o    <= 1'b0;
        end else begin
            if ((state_q == ST_IDLE) && start_i) begin
                base_q_o <= base_i;
                cls_q_o  <= avl_cls_e'(cls_i);
            end
            if ((state_q == ST_DECIDE) && bad_i) begin
                err_o <= 1'b1;
            end
            if ((state_q == ST_SRCH_L1) && found_i) begin
                r_l1_o <= idx_i;
            end
            if ((state_q == ST_SRCH_L23) && found_i) begin
                r_l23_o <= idx_i;
            end
            if ((state_q == ST_SRCH_MIN) && found_i) begin
                lvl0_o <= res_l0_i;
                lvl1_o <= res_l1_i;
                lvl2_o <= res_l2_i;
                lvl3_o <= res_l3_i;
                err_o  <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/avl_calc.sv
module avl_calc
    import avl_pkg::*;
#(
    parameter int TBL_N         = 52,
    parameter int MV_BASE       = 747,
    parameter int STEP_NUM      = 35,
    parameter int STEP_DEN      = 3,
    parameter int FLOOR_MV      = 1000,
    parameter int DROP_L1_MV    = 100,
    parameter int DROP_L23_MV   = 150,
    parameter int MIN_L1_MID_MV = 1108,
    parameter int MIN_L1_TOP_MV = 1155,
    parameter int CODE_W        = $clog2(TBL_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CODE_W-1:0] base_code_i,
    input  logic [1:0]        freq_class_i,
    output logic [CODE_W-1:0] lvl0_code_o,
    output logic [CODE_W-1:0] lvl1_code_o,
    output logic [CODE_W-1:0] lvl2_code_o,
    output logic [CODE_W-1:0] lvl3_code_o,
    output logic              done_o,
    output logic              err_o
);
    timeunit 1ns;
    timeprecision 1ps;

    localparam int TBL_TOP_MV = MV_BASE + ((TBL_N - 1) * STEP_NUM) / STEP_DEN;
    localparam int MIN_HI_MV  = (MIN_L1_TOP_MV > MIN_L1_MID_MV) ? MIN_L1_TOP_MV : MIN_L1_MID_MV;
    localparam int MV_CEIL    = (TBL_TOP_MV > MIN_HI_MV) ? TBL_TOP_MV : MIN_HI_MV;
    localparam int MV_W       = $clog2(MV_CEIL + 1);

    logic              bad;
    logic              low;
    logic              apply_min;
    logic [MV_W-1:0]   t_l1;
    logic [MV_W-1:0]   t_l23;
    logic [MV_W-1:0]   t_min;
    logic              go;
    logic [MV_W-1:0]   target;
    logic              found;
    logic [CODE_W-1:0] idx;
    logic [CODE_W-1:0] base_q;
    avl_cls_e          cls_q;
    logic [CODE_W-1:0] r_l1;
    logic [CODE_W-1:0] r_l23;
    logic [CODE_W-1:0] res_l0;
    logic [CODE_W-1:0] res_l1;
    logic [CODE_W-1:0] res_l2;
    logic [CODE_W-1:0] res_l3;

    avl_target #(
        .CODE_W(CODE_W), .TBL_N(TBL_N), .MV_W(MV_W), .MV_BASE(MV_BASE),
        .STEP_NUM(STEP_NUM), .STEP_DEN(STEP_DEN), .FLOOR_MV(FLOOR_MV),
        .DROP_L1_MV(DROP_L1_MV), .DROP_L23_MV(DROP_L23_MV),
        .MIN_L1_MID_MV(MIN_L1_MID_MV), .MIN_L1_TOP_MV(MIN_L1_TOP_MV)
    ) u_target (
        .base_i(base_q), .cls_i(cls_q), .bad_o(bad), .low_o(low),
        .apply_min_o(apply_min), .t_l1_o(t_l1), .t_l23_o(t_l23), .t_min_o(t_min)
    );

    avl_search #(
        .CODE_W(CODE_W), .TBL_N(TBL_N), .MV_W(MV_W), .MV_BASE(MV_BASE),
        .STEP_NUM(STEP_NUM), .STEP_DEN(STEP_DEN)
    ) u_search (
        .clk(clk), .rst_n(rst_n), .go_i(go), .target_i(target),
        .found_o(found), .idx_o(idx)
    );

    avl_resolve #(
        .CODE_W(CODE_W)
    ) u_resolve (
        .base_i(base_q), .low_i(low), .apply_min_i(apply_min),
        .r_l1_i(r_l1), .r_l23_i(r_l23), .r_min_i(idx),
        .lvl0_o(res_l0), .lvl1_o(res_l1), .lvl2_o(res_l2), .lvl3_o(res_l3)
    );

    avl_ctrl #(
        .CODE_W(CODE_W), .MV_W(MV_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_code_i),
        .cls_i(freq_class_i), .bad_i(bad), .t_l1_i(t_l1), .t_l23_i(t_l23),
        .t_min_i(t_min), .found_i(found), .idx_i(idx),
        .res_l0_i(res_l0), .res_l1_i(res_l1), .res_l2_i(res_l2), .res_l3_i(res_l3),
        .go_o(go), .target_o(target), .base_q_o(base_q), .cls_q_o(cls_q),
        .r_l1_o(r_l1), .r_l23_o(r_l23),
        .lvl0_o(lvl0_code_o), .lvl1_o(lvl1_code_o), .lvl2_o(lvl2_code_o),
        .lvl3_o(lvl3_code_o), .done_o(done_o), .err_o(err_o)
    );
endmodule

// File: rtl/avl_calc_chk.sv
module avl_calc_chk #(
    parameter int CODE_W = 6,
    parameter int TBL_N  = 52
) (
    input logic              clk,
    input logic              rst_n,
    input logic              done,
    input logic              err,
    input logic [CODE_W-1:0] l0,
    input logic [CODE_W-1:0] l1,
    input logic [CODE_W-1:0] l2,
    input logic [CODE_W-1:0] l3
);
    timeunit 1ns;
    timeprecision 1ps;

    a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_codes_move_only_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable({l0, l1, l2, l3}));

    a_r4_err_keeps_codes: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> $stable({l0, l1, l2, l3}));

    a_r4_err_rises_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> done);

    a_r4_err_falls_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err) |-> done);

    a_r2_codes_in_table: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> ((int'(l0) < TBL_N) && (int'(l1) < TBL_N) &&
                            (int'(l2) < TBL_N) && (int'(l3) < TBL_N)));

    a_r7_level_order: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> ((l2 == l3) && (l2 <= l1)));
endmodule

bind avl_calc avl_calc_chk #(.CODE_W(CODE_W), .TBL_N(TBL_N)) u_chk (
    .clk(clk), .rst_n(rst_n), .done(done_o), .err(err_o),
    .l0(lvl0_code_o), .l1(lvl1_code_o), .l2(lvl2_code_o), .l3(lvl3_code_o)
);

// File: tb/tb_avl_calc.sv
module tb_avl_calc;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [5:0] base = '0;
    logic [1:0] cls = '0;
    logic [5:0] l0, l1, l2, l3;
    logic       done, err;
    logic [5:0] s0, s1, s2, s3;
    logic       s_done, s_err;

    always #2 clk = ~clk;

    avl_calc dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_code_i(base),
        .freq_class_i(cls), .lvl0_code_o(l0), .lvl1_code_o(l1),
        .lvl2_code_o(l2), .lvl3_code_o(l3), .done_o(done), .err_o(err)
    );

    avl_calc #(.MIN_L1_TOP_MV(1400)) dut_sat (
        .clk(clk), .rst_n(rst_n), .start_i(start), .base_code_i(base),
        .freq_class_i(cls), .lvl0_code_o(s0), .lvl1_code_o(s1),
        .lvl2_code_o(s2), .lvl3_code_o(s3), .done_o(s_done), .err_o(s_err)
    );

    int mvt[52] = '{747, 758, 770, 782, 793, 805, 817, 828, 840, 852, 863, 875, 887,
                    898, 910, 922, 933, 945, 957, 968, 980, 992, 1003, 1015, 1027,
                    1038, 1050, 1062, 1073, 1085, 1097, 1108, 1120, 1132, 1143, 1155,
                    1167, 1178, 1190, 1202, 1213, 1225, 1237, 1248, 1260, 1272, 1283,
                    1295, 1307, 1318, 1330, 1342};

    int    n_cmp = 0;
    int    n_fail = 0;
    string cur_req = "R1";

    function automatic int match_mv(input int t);
        for (int i = 0; i < 52; i++) begin
            if (mvt[i] >= t) return i;
        end
        return 51;
    endfunction

    function automatic void predict(input int b, input int c, input int top_mv,
                                    output int e0, output int e1, output int e2,
                                    output int e3, output bit bad, output int lat);
        int mv, t1, t2, r1, r2, rm, lim;
        e0 = 0; e1 = 0; e2 = 0; e3 = 0;
        if (b >= 52) begin
            bad = 1'b1;
            lat = 1;
            return;
        end
        bad = 1'b0;
        mv = mvt[b];
        t1 = (mv - 100 > 1000) ? mv - 100 : 1000;
        t2 = (mv - 150 > 1000) ? mv - 150 : 1000;
        r1 = match_mv(t1);
        r2 = match_mv(t2);
        rm = match_mv((c == 3) ? top_mv : 1108);
        lat = r1 + r2 + rm + 4;
        if (mv <= 1000) begin
            e1 = match_mv(1000); e2 = e1; e3 = e1; e0 = b;
            if (c >= 2) begin
                e0 = rm; e1 = rm;
            end
        end else begin
            e0 = b; e1 = r1; e2 = r2; e3 = r2;
            if (c >= 2) begin
                lim = (rm > b) ? b : rm;
                if (e1 < lim) e1 = lim;
            end
        end
    endfunction

    // Reference model, advanced once per rising edge.
    int m_cnt = 0;
    bit m_done = 1'b0;
    bit m_err = 1'b0;
    bit p_err = 1'b0;
    int m_l0 = 0, m_l1 = 0, m_l2 = 0, m_l3 = 0;
    int p_l0 = 0, p_l1 = 0, p_l2 = 0, p_l3 = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_done = 1'b0; m_err = 1'b0;
            m_l0 = 0; m_l1 = 0; m_l2 = 0; m_l3 = 0;
        end else if (m_done) begin
            m_done = 1'b0;
        end else if (m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_done = 1'b1;
                if (p_err) begin
                    m_err = 1'b1;
                end else begin
                    m_err = 1'b0;
                    m_l0 = p_l0; m_l1 = p_l1; m_l2 = p_l2; m_l3 = p_l3;
                end
            end
        end else if (start) begin
            predict(int'(base), int'(cls), 1155, p_l0, p_l1, p_l2, p_l3, p_err, m_cnt);
        end
    end

    always @(negedge clk) begin
        logic [25:0] act, exp_v;
        act   = {done, err, l0, l1, l2, l3};
        exp_v = {m_done, m_err, 6'(m_l0), 6'(m_l1), 6'(m_l2), 6'(m_l3)};
        n_cmp++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: actual done/err/codes %h expected %h", cur_req, act, exp_v);
        end
    end

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    endtask

    task automatic run(input int b, input int c, input string req);
        cur_req = req;
        @(negedge clk);
        base = 6'(b); cls = 2'(c); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_cnt > 0 || m_done) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        int e0, e1, e2, e3, lat;
        bit bad;
        cur_req = "R1";
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        run(10, 0, "R5");
        run(21, 1, "R5");
        run(15, 2, "R6");
        run(5, 3, "R6");
        run(22, 0, "R7");
        run(40, 0, "R7");
        run(40, 2, "R8");
        run(33, 2, "R8");
        run(33, 3, "R8");
        run(33, 1, "R8");
        run(51, 0, "R2");
        run(45, 1, "R9");
        run(0, 3, "R3");
        run(52, 2, "R4");
        run(63, 0, "R4");
        run(30, 0, "R4");

        // R10: a second start while busy is ignored.
        cur_req = "R10";
        @(negedge clk);
        base = 6'd30; cls = 2'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        base = 6'd5; cls = 2'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_cnt > 0 || m_done) @(negedge clk);
        // R10: a start during the done cycle is ignored.
        @(negedge clk);
        base = 6'd45; cls = 2'd0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!m_done) @(negedge clk);
        base = 6'd10; cls = 2'd2; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);

        // R3: scan saturates at the last code on the raised-minimum instance.
        repeat (200) @(negedge clk);
        run(51, 3, "R3");
        for (int k = 0; k < 300 && !s_done; k++) @(negedge clk);
        predict(51, 3, 1400, e0, e1, e2, e3, bad, lat);
        n_cmp++;
        if (!s_done || s_err || {s0, s1, s2, s3} !== {6'(e0), 6'(e1), 6'(e2), 6'(e3)}) begin
            n_fail++;
            $display("FAIL R3: actual done=%0b codes %0d %0d %0d %0d expected done=1 codes %0d %0d %0d %0d",
                     s_done, s0, s1, s2, s3, e0, e1, e2, e3);
        end
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule